// File: doc/BRIEF.md
# Debug Trigger Qualifier

This block sits between the address comparators of a processor's debug logic and its exception unit. Each cycle it takes the hit indications from one instruction breakpoint comparator and from a set of data watchpoint comparators. It qualifies each hit against the current privilege class (problem state, hypervisor state) and the data translation mode. It then reports which sources really fire.

When something fires, the block requests an exception and supplies its kind. It also supplies the values that the exception unit loads into the data-address register and the interrupt status register. A qualified watchpoint raises a data storage exception and captures the faulting address. A qualified breakpoint raises a trace exception. The address comparison and the delivery sequence are done elsewhere.

A three-state machine (FS_QUIET, FS_DATA_FIRE, FS_TRACE_FIRE) holds the registered decision. From any state it moves to FS_DATA_FIRE when a qualified watchpoint hit is present. It moves to FS_TRACE_FIRE when only a qualified breakpoint hit is present. Otherwise it moves to FS_QUIET.

Top module: `dbg_trig_qual`

## Requirements
- R1: Breakpoint privilege field value 1 lets a breakpoint hit fire only while problem state is set.
- R2: Breakpoint privilege field value 2 fires only with problem and hypervisor both clear, and value 3 fires only with problem clear and hypervisor set.
- R3: Breakpoint privilege field value 0 disables the breakpoint, so bp_match never rises.
- R4: Each 64-bit watchpoint control word uses big-endian bit numbering, with bit 0 the most significant. The enables are WT at bit 59, WTI at bit 60, HV at 61, SV at 62 and PR at 63, which are little-endian indices 4, 3, 2, 1 and 0. A hit is rejected if problem state is set and PR is clear. Failing that, it is rejected if hypervisor is set and HV is clear. Failing that, it is rejected if SV is clear. All other control bits are ignored.
- R5: A watchpoint that passes R4 with WTI clear fires only when WT equals the data-relocation bit. With WTI set, the relocation bit is ignored.
- R6: Watchpoint 1 and any higher watchpoint can fire only while feat_ext is high. Watchpoint 0 does not depend on feat_ext.
- R7: A qualified watchpoint sets exc_req, sets exc_kind to 2'b01 (data storage) and sets dar_we. It drives dar_val with hit_addr and drives status_val with only big-endian bit 41 set (little-endian index 22).
- R8: A qualified breakpoint alone sets exc_req and sets exc_kind to 2'b10 (trace). It drives status_val with only big-endian bits 33 and 43 set (little-endian indices 30 and 20), keeps dar_we low and drives dar_val as zero.
- R9: When a qualified watchpoint and a qualified breakpoint occur in the same cycle, the data storage response of R7 wins. Both match flags are still reported.
- R10: All outputs are registered: they reflect the inputs of the previous clock edge. Reset clears them all to zero (exc_kind 2'b00, none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_problem | input | 1 | Problem (user) state is active |
| st_hyper | input | 1 | Hypervisor state is active |
| st_reloc | input | 1 | Data address translation is on |
| feat_ext | input | 1 | Newer architecture level present; enables watchpoints 1 and up |
| bp_priv | input | 2 | Breakpoint privilege class selector |
| bp_addr_hit | input | 1 | Breakpoint address comparator hit |
| wp_ctl | input | NUM_WP x CTRL_W | Watchpoint control words |
| wp_addr_hit | input | NUM_WP | Watchpoint address comparator hits |
| hit_addr | input | AW | Data address that caused the watchpoint hit |
| bp_match | output | 1 | Qualified breakpoint hit |
| wp_match | output | NUM_WP | Qualified watchpoint hits |
| exc_req | output | 1 | Exception request |
| exc_kind | output | 2 | 00 none, 01 data storage, 10 trace |
| dar_we | output | 1 | Load the data-address register |
| dar_val | output | AW | Value for the data-address register |
| status_val | output | STAT_W | Value for the interrupt status register |

## Verification
The breakpoint is tried with all four privilege selector values against all four problem/hypervisor combinations. This separates the disabled value from the three privilege classes. Watchpoint 0 is swept through every combination of its five enable bits against every privilege and translation state, with random upper control bits. This exposes the order of the rejection chain and the WT/WTI translation rule, and shows that bits outside the field have no effect. Watchpoint 1 alone is swept with feat_ext low and then high. Forced simultaneous hits on both kinds of source test the priority. A long random run then mixes every input at once.

// File: rtl/dbg_qual_pkg.sv
package dbg_qual_pkg;

    typedef enum logic [1:0] {
        FS_QUIET      = 2'b00,
        FS_DATA_FIRE  = 2'b01,
        FS_TRACE_FIRE = 2'b10
    } fire_state_e;

    // number of enable bits at the bottom of a watchpoint control word
    localparam int unsigned WP_FIELD_W = 5;

    // converts a big-endian bit number into a little-endian index
    function automatic int unsigned be_idx(input int unsigned width, input int unsigned bitn);
        return width - 1 - bitn;
    endfunction

endpackage

// File: rtl/dbg_bp_qual.sv
module dbg_bp_qual (
    input  logic       problem,
    input  logic       hyper,
    input  logic [1:0] priv_sel,
    input  logic       addr_hit,
    output logic       fire
);
    logic class_ok;

    always_comb begin
        unique case (priv_sel)
            2'd1:    class_ok = problem;
            2'd2:    class_ok = !problem && !hyper;
            2'd3:    class_ok = !problem && hyper;
            default: class_ok = 1'b0;
        endcase
    end

    assign fire = addr_hit && class_ok;

endmodule

// File: rtl/dbg_wp_qual.sv
module dbg_wp_qual #(
    parameter int unsigned CTRL_W = 64,
    parameter bit          GATED  = 1'b0
) (
    input  logic [CTRL_W-1:0] ctl,
    input  logic              problem,
    input  logic              hyper,
    input  logic              reloc,
    input  logic              feat_ext,
    input  logic              addr_hit,
    output logic              fire
);
    import dbg_qual_pkg::*;

    localparam int unsigned WT_IX  = be_idx(64, 59);
    localparam int unsigned WTI_IX = be_idx(64, 60);
    localparam int unsigned HV_IX  = be_idx(64, 61);
    localparam int unsigned SV_IX  = be_idx(64, 62);
    localparam int unsigned PR_IX  = be_idx(64, 63);

    logic en_wt, en_wti, en_hv, en_sv, en_pr;
    logic priv_ok, xlate_ok, usable;
    logic unused_hi;

    assign en_wt  = ctl[WT_IX];
    assign en_wti = ctl[WTI_IX];
    assign en_hv  = ctl[HV_IX];
    assign en_sv  = ctl[SV_IX];
    assign en_pr  = ctl[PR_IX];
    assign unused_hi = ^ctl[CTRL_W-1:WP_FIELD_W];

    // rejection chain, checked in priority order
    always_comb begin
        if (problem && !en_pr) begin
            priv_ok = 1'b0;
        end else if (hyper && !en_hv) begin
            priv_ok = 1'b0;
        end else if (!en_sv) begin
            priv_ok = 1'b0;
        end else begin
            priv_ok = 1'b1;
        end
    end

    always_comb begin
        if (en_wti) begin
            xlate_ok = 1'b1;
        end else begin
            xlate_ok = (en_wt == reloc);
        end
    end

    generate
        if (GATED) begin : g_gated
            assign usable = feat_ext;
        end else begin : g_free
            logic unused_feat;
            assign unused_feat = feat_ext;
            assign usable = 1'b1;
        end
    endgenerate

    assign fire = addr_hit && usable && priv_ok && xlate_ok;

endmodule

// File: rtl/dbg_fire_fsm.sv
module dbg_fire_fsm #(
    parameter int unsigned NUM_WP = 2,
    parameter int unsigned AW     = 64,
    parameter int unsigned STAT_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_WP-1:0] wp_fire,
    input  logic              bp_fire,
    input  logic [AW-1:0]     hit_addr,
    output logic              bp_match,
    output logic [NUM_WP-1:0] wp_match,
    output logic              exc_req,
    output logic [1:0]        exc_kind,
    output logic              dar_we,
    output logic [AW-1:0]     dar_val,
    output logic [STAT_W-1:0] status_val
);
    import dbg_qual_pkg::*;

    localparam logic [STAT_W-1:0] DATA_STAT  = STAT_W'(1) << be_idx(STAT_W, 41);
    localparam logic [STAT_W-1:0] TRACE_STAT = (STAT_W'(1) << be_idx(STAT_W, 33))
                                             | (STAT_W'(1) << be_idx(STAT_W, 43));

    fire_state_e state_q, state_d;
    logic [AW-1:0]     addr_q;
    logic [NUM_WP-1:0] wp_q;
    logic              bp_q;

    always_comb begin
        if (|wp_fire) begin
            state_d = FS_DATA_FIRE;
        end else if (bp_fire) begin
            state_d = FS_TRACE_FIRE;
        end else begin
            state_d = FS_QUIET;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            wp_q   <= '0;
            bp_q   <= 1'b0;
        end else begin
            addr_q <= (|wp_fire) ? hit_addr : '0;
            wp_q   <= wp_fire;
            bp_q   <= bp_fire;
        end
    end

    always_comb begin
        exc_req    = 1'b0;
        dar_we     = 1'b0;
        status_val = '0;
        unique case (state_q)
            FS_DATA_FIRE: begin
                exc_req    = 1'b1;
                dar_we     = 1'b1;
                status_val = DATA_STAT;
            end
            FS_TRACE_FIRE: begin
                exc_req    = 1'b1;
                status_val = TRACE_STAT;
            end
            default: begin
                exc_req = 1'b0;
            end
        endcase
    end

    assign exc_kind = state_q;
    assign dar_val  = addr_q;
    assign wp_match = wp_q;
    assign bp_match = bp_q;

    // R7
    data_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_kind == 2'b01) |-> (dar_we && status_val == DATA_STAT && dar_val == $past(hit_addr)));

    // R8
    trace_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_kind == 2'b10) |-> (!dar_we && status_val == TRACE_STAT && dar_val == '0));

    // R9
    wp_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wp_match) |-> (exc_kind == 2'b01));

    // R10
    onehot_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(exc_kind) && (exc_req == (exc_kind != 2'b00)));

endmodule

// File: rtl/dbg_trig_qual.sv
module dbg_trig_qual #(
    parameter int unsigned NUM_WP = 2,
    parameter int unsigned CTRL_W = 64,
    parameter int unsigned AW     = 64,
    parameter int unsigned STAT_W = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          st_problem,
    input  logic                          st_hyper,
    input  logic                          st_reloc,
    input  logic                          feat_ext,
    input  logic [1:0]                    bp_priv,
    input  logic                          bp_addr_hit,
    input  logic [NUM_WP-1:0][CTRL_W-1:0] wp_ctl,
    input  logic [NUM_WP-1:0]             wp_addr_hit,
    input  logic [AW-1:0]                 hit_addr,
    output logic                          bp_match,
    output logic [NUM_WP-1:0]             wp_match,
    output logic                          exc_req,
    output logic [1:0]                    exc_kind,
    output logic                          dar_we,
    output logic [AW-1:0]                 dar_val,
    output logic [STAT_W-1:0]             status_val
);
    logic              bp_fire;
    logic [NUM_WP-1:0] wp_fire;

    dbg_bp_qual u_bp (
        .problem  (st_problem),
        .hyper    (st_hyper),
        .priv_sel (bp_priv),
        .addr_hit (bp_addr_hit),
        .fire     (bp_fire)
    );

    generate
        for (genvar gi = 0; gi < NUM_WP; gi++) begin : g_wp
            dbg_wp_qual #(
                .CTRL_W (CTRL_W),
                .GATED  (gi != 0)
            ) u_wp (
                .ctl      (wp_ctl[gi]),
                .problem  (st_problem),
                .hyper    (st_hyper),
                .reloc    (st_reloc),
                .feat_ext (feat_ext),
                .addr_hit (wp_addr_hit[gi]),
                .fire     (wp_fire[gi])
            );
        end
    endgenerate

    dbg_fire_fsm #(
        .NUM_WP (NUM_WP),
        .AW     (AW),
        .STAT_W (STAT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wp_fire    (wp_fire),
        .bp_fire    (bp_fire),
        .hit_addr   (hit_addr),
        .bp_match   (bp_match),
        .wp_match   (wp_match),
        .exc_req    (exc_req),
        .exc_kind   (exc_kind),
        .dar_we     (dar_we),
        .dar_val    (dar_val),
        .status_val (status_val)
    );

    // R3
    bp_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_priv == 2'd0) |=> !bp_match);

    // R1
    bp_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_priv == 2'd1 && !st_problem) |=> !bp_match);

    // R6
    generate
        if (NUM_WP > 1) begin : g_gate_chk
            wp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !feat_ext |=> (wp_match[NUM_WP-1:1] == '0));
        end
    endgenerate

    // R4
    wp_sv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_ctl[0][1] |=> !wp_match[0]);

endmodule

// File: tb/tb_dbg_trig_qual.sv
`timescale 1ns/1ps
module tb_dbg_trig_qual;
    localparam int NUM_WP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_problem = 0, st_hyper = 0, st_reloc = 0, feat_ext = 0;
    logic [1:0] bp_priv = 0;
    logic bp_addr_hit = 0;
    logic [NUM_WP-1:0][63:0] wp_ctl = '0;
    logic [NUM_WP-1:0] wp_addr_hit = '0;
    logic [63:0] hit_addr = '0;
    logic bp_match, exc_req, dar_we;
    logic [NUM_WP-1:0] wp_match;
    logic [1:0] exc_kind;
    logic [63:0] dar_val, status_val;

    int n_cmp = 0;
    int n_bad = 0;
    logic [134:0] exp_vec = '0;
    string exp_tag = "R10 reset";

    always #2.5 clk = ~clk;

    dbg_trig_qual dut (
        .clk(clk), .rst_n(rst_n), .st_problem(st_problem), .st_hyper(st_hyper),
        .st_reloc(st_reloc), .feat_ext(feat_ext), .bp_priv(bp_priv),
        .bp_addr_hit(bp_addr_hit), .wp_ctl(wp_ctl), .wp_addr_hit(wp_addr_hit),
        .hit_addr(hit_addr), .bp_match(bp_match), .wp_match(wp_match),
        .exc_req(exc_req), .exc_kind(exc_kind), .dar_we(dar_we),
        .dar_val(dar_val), .status_val(status_val)
    );

    function automatic bit ref_bp(int priv, bit pr, bit hv);
        if (priv == 1) return pr;
        if (priv == 2) return !pr && !hv;
        if (priv == 3) return !pr && hv;
        return 0;
    endfunction

    function automatic bit ref_wp(logic [63:0] c, bit pr, bit hv, bit dr);
        if (pr && c[0] == 0) return 0;
        if (hv && c[2] == 0) return 0;
        if (c[1] == 0) return 0;
        if (c[3] == 1) return 1;
        return c[4] == dr;
    endfunction

    function automatic logic [134:0] act_vec();
        return {bp_match, wp_match, exc_req, exc_kind, dar_we, dar_val, status_val};
    endfunction

    task automatic compare();
        n_cmp++;
        if (act_vec() !== exp_vec) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", exp_tag, act_vec(), exp_vec);
        end
    endtask

    // compare previous cycle, then drive new inputs and predict
    task automatic drive(bit pr, bit hv, bit dr, bit fx, int priv, bit bph,
                         logic [63:0] c0, logic [63:0] c1, logic [1:0] wph,
                         logic [63:0] addr, string tag);
        bit eb;
        bit [1:0] ew;
        logic [63:0] st;
        logic [1:0] k;
        @(negedge clk);
        compare();
        st_problem = pr; st_hyper = hv; st_reloc = dr; feat_ext = fx;
        bp_priv = priv[1:0]; bp_addr_hit = bph; wp_ctl[0] = c0; wp_ctl[1] = c1;
        wp_addr_hit = wph; hit_addr = addr;
        eb = bph && ref_bp(priv, pr, hv);
        ew[0] = wph[0] && ref_wp(c0, pr, hv, dr);
        ew[1] = wph[1] && fx && ref_wp(c1, pr, hv, dr);
        if (ew != 0) begin
            k = 2'b01; st = 64'd1 << 22;
            exp_tag = (eb) ? {tag, " R9"} : {tag, " R7"};
        end else if (eb) begin
            k = 2'b10; st = (64'd1 << 30) | (64'd1 << 20);
            exp_tag = {tag, " R8"};
        end else begin
            k = 2'b00; st = 0;
            exp_tag = tag;
        end
        exp_vec = {eb, ew, (k != 0), k, (k == 2'b01), (k == 2'b01) ? addr : 64'd0, st};
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog: actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare();   // R10 reset state
        rst_n = 1'b1;
        // R1 R2 R3 breakpoint privilege sweep
        for (int p = 0; p < 4; p++)
            for (int s = 0; s < 4; s++)
                drive(s[0], s[1], 0, 0, p, 1, 0, 0, 2'b00, rnd64(), "R1 R2 R3 bp");
        // R4 R5 watchpoint 0 enable sweep, upper control bits random
        for (int c = 0; c < 32; c++)
            for (int s = 0; s < 8; s++)
                drive(s[0], s[1], s[2], 0, 0, 0, {rnd64() >> 5, c[4:0]}, 0,
                      2'b01, rnd64(), "R4 R5 wp0");
        // R6 watchpoint 1 gating
        for (int f = 0; f < 2; f++)
            for (int c = 0; c < 32; c++)
                for (int s = 0; s < 8; s++)
                    drive(s[0], s[1], s[2], f[0], 0, 0, 64'h1f, {rnd64() >> 5, c[4:0]},
                          2'b10, rnd64(), "R6 wp1");
        // R9 simultaneous watchpoint and breakpoint
        for (int i = 0; i < 200; i++)
            drive($urandom % 2, $urandom % 2, $urandom % 2, 1, 1 + ($urandom % 3), 1,
                  64'h1f, rnd64(), 2'b11, rnd64(), "R9 both");
        // R10 random mix
        for (int i = 0; i < 2000; i++)
            drive($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 4,
                  $urandom % 2, rnd64(), rnd64(), 2'($urandom), rnd64(), "R10 random");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 0, "R10 idle");
        @(negedge clk);
        compare();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule